// File: doc/BRIEF.md
# Peripheral Event Transfer Engine

This block gives a set of independent channels a fast way to answer an interrupt with a data move instead of a full interrupt entry. When a trigger routed to a channel arrives, the engine takes a short bus slot from the processor. In that slot it reads one byte or one word at the channel's source address and writes the element to the channel's destination address. It then advances the selected pointer and counts the service down.

Each channel holds a source pointer, a destination pointer and a control word. The control word carries a count, an element size, a pointer-advance selection and a free-running flag. When a normal countdown reaches zero, the channel fires its standard interrupt line, so that the processor can run a real handler, for example at the end of a block. A channel that is triggered with its count already exhausted skips the move and forwards the request as an interrupt at once. A channel in free-running mode keeps moving data and never counts.

The channel registers are written and read back through a small configuration port. The memory side is a plain request/write-enable bus with a combinational read return.

Top module: `evt_xfer_unit`

## Requirements
- R1: There are NCH channels (default 8), each with its own registers. The configuration port selects a register with sel 0 for the source pointer, 1 for the destination pointer and 2 for the control word; sel 3 reads zero. Control word bits, with CW=8: [7:0] count, [8] word size (1 = 16-bit, 0 = byte), [10:9] advance mode (01 = source, 10 = destination, 00 or 11 = none), [11] free-running.
- R2: A service reads one element at the source pointer and then writes that same element to the destination pointer. bus_size_o is 1 for a word. A byte is carried in bits [7:0] of the write data, and the upper bits are zero.
- R3: After a service, the pointer chosen by the advance mode grows by 2 for a word or by 1 for a byte. The other pointer keeps its value, and mode 00 or 11 leaves both unchanged.
- R4: A service holds steal_o and bus_req_o high for exactly two cycles: a read cycle (bus_we_o low) followed by a write cycle (bus_we_o high). done_o pulses for one cycle in the cycle after the write.
- R5: Without free-running mode, the count drops by exactly one for each completed service.
- R6: In free-running mode a service leaves the count unchanged and never raises the channel's interrupt, even when the count is zero.
- R7: When a service brings the count from 1 to 0, irq_o for that channel pulses for one cycle together with done_o. At most one irq_o bit is high in any cycle.
- R8: A trigger on a channel that is not free-running and whose count is already zero causes no bus access and no change to the pointers. The channel's irq_o pulses for one cycle, without done_o.
- R9: When several channels have pending triggers, the highest-numbered one is served first. The others stay pending and are served in later slots.
- R10: After reset every pointer and control word reads zero, and steal_o, bus_req_o, done_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NCH | Interrupt triggers routed to the channels (one-cycle pulses) |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_ch_i | input | $clog2(NCH) | Channel selected for configuration access |
| cfg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wdata_i | input | AW | Configuration write data |
| cfg_rdata_o | output | AW | Read-back of the selected register |
| bus_req_o | output | 1 | Bus access active |
| bus_we_o | output | 1 | Write cycle when high, read cycle when low |
| bus_size_o | output | 1 | Element size: 1 word, 0 byte |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid in the cycle of the read |
| steal_o | output | 1 | Processor slot taken by the engine |
| done_o | output | 1 | One-cycle pulse after a completed move |
| irq_o | output | NCH | Standard interrupt pulse per channel |

## Verification
The bench uses the default parameters: eight channels, 16-bit addresses and data, and an 8-bit count. With these values, small counts of 2 and 3 reach zero after a few services, and the channel extremes 0 and 7 can be used as well as a simultaneous trigger on channels 6 and 1. Byte and word sizes are combined with every advance mode, free-running mode is run from a zero count, and an exhausted channel is triggered. Every bus write is compared in order against a queue that the bench predicts from its own memory image.

// File: rtl/pet_pkg.sv
package pet_pkg;

  // register selects on the configuration port
  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // pointer-advance mode codes
  localparam logic [1:0] ADV_SRC = 2'b01;
  localparam logic [1:0] ADV_DST = 2'b10;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } eng_state_t;

endpackage

// File: rtl/pet_pick.sv
module pet_pick #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]         req,
  output logic                   vld,
  output logic [$clog2(NCH)-1:0] idx
);
  localparam int CHW = $clog2(NCH);

  // ascending scan: the last hit, the highest index, wins
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/pet_chan.sv
module pet_chan
  import pet_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            upd_en,
  input  logic [AW-1:0]   upd_src,
  input  logic [AW-1:0]   upd_dst,
  input  logic [CW-1:0]   upd_cnt,
  input  logic            trig,
  input  logic            clr,
  output logic [AW-1:0]   src_q,
  output logic [AW-1:0]   dst_q,
  output logic [CW+3:0]   ctrl_q,
  output logic            pend_q
);
  localparam int CTRLW = CW + 4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (upd_en) begin
        src_q          <= upd_src;
        dst_q          <= upd_dst;
        ctrl_q[CW-1:0] <= upd_cnt;
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SRC:  src_q  <= cfg_wdata;
          SEL_DST:  dst_q  <= cfg_wdata;
          SEL_CTRL: ctrl_q <= cfg_wdata[CTRLW-1:0];
          default:  ;
        endcase
      end
      // a new trigger beats the clear of the one being taken
      pend_q <= trig | (pend_q & ~clr);
    end
  end
endmodule

// File: rtl/pet_engine.sv
module pet_engine
  import pet_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DW  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pick_vld,
  input  logic [$clog2(NCH)-1:0]     pick_ch,
  input  logic [NCH-1:0][AW-1:0]     src_all,
  input  logic [NCH-1:0][AW-1:0]     dst_all,
  input  logic [NCH-1:0][CW+3:0]     ctrl_all,
  input  logic [DW-1:0]              bus_rdata,
  output logic [NCH-1:0]             clr_oh,
  output logic [NCH-1:0]             upd_oh,
  output logic [AW-1:0]              upd_src,
  output logic [AW-1:0]              upd_dst,
  output logic [CW-1:0]              upd_cnt,
  output logic                       bus_req,
  output logic                       bus_we,
  output logic                       bus_size,
  output logic [AW-1:0]              bus_addr,
  output logic [DW-1:0]              bus_wdata,
  output logic                       done,
  output logic [NCH-1:0]             irq,
  output logic [$clog2(NCH)-1:0]     ev_ch,
  output logic                       ev_cont,
  output logic                       ev_skip
);
  localparam int CHW    = $clog2(NCH);
  localparam int F_WORD = CW;
  localparam int F_ADV  = CW + 1;
  localparam int F_CONT = CW + 3;

  // pointer after one service
  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p,
                                             input logic adv,
                                             input logic word);
    return adv ? p + (word ? AW'(2) : AW'(1)) : p;
  endfunction

  // count after one service
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic free_run);
    return free_run ? c : c - CW'(1);
  endfunction

  eng_state_t     state;
  logic [CHW-1:0] ch_q;
  logic [DW-1:0]  data_q;
  logic           done_q;
  logic           skip_q;
  logic [NCH-1:0] irq_q;

  logic [CW+3:0] cur_ctrl, pick_ctrl;
  logic [1:0]    cur_adv;
  logic          cur_word, cur_cont, pick_exhausted;

  assign cur_ctrl       = ctrl_all[ch_q];
  assign pick_ctrl      = ctrl_all[pick_ch];
  assign cur_word       = cur_ctrl[F_WORD];
  assign cur_adv        = cur_ctrl[F_ADV+1:F_ADV];
  assign cur_cont       = cur_ctrl[F_CONT];
  assign pick_exhausted = !pick_ctrl[F_CONT] && (pick_ctrl[CW-1:0] == '0);

  assign upd_src = step_ptr(src_all[ch_q], cur_adv == ADV_SRC, cur_word);
  assign upd_dst = step_ptr(dst_all[ch_q], cur_adv == ADV_DST, cur_word);
  assign upd_cnt = next_count(cur_ctrl[CW-1:0], cur_cont);

  always_comb begin
    clr_oh = '0;
    upd_oh = '0;
    if (state == ST_IDLE && pick_vld) clr_oh[pick_ch] = 1'b1;
    if (state == ST_WRITE)            upd_oh[ch_q]    = 1'b1;
  end

  assign bus_req   = (state != ST_IDLE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_size  = cur_word;
  assign bus_addr  = (state == ST_READ) ? src_all[ch_q] : dst_all[ch_q];
  assign bus_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ch_q   <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      skip_q <= 1'b0;
      irq_q  <= '0;
    end else begin
      done_q <= 1'b0;
      skip_q <= 1'b0;
      irq_q  <= '0;
      case (state)
        ST_IDLE: begin
          if (pick_vld) begin
            ch_q <= pick_ch;
            if (pick_exhausted) begin
              irq_q[pick_ch] <= 1'b1;
              skip_q         <= 1'b1;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          data_q <= cur_word ? bus_rdata : DW'(bus_rdata[BYTE_W-1:0]);
          state  <= ST_WRITE;
        end
        ST_WRITE: begin
          done_q <= 1'b1;
          if (!cur_cont && upd_cnt == '0) irq_q[ch_q] <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign irq     = irq_q;
  assign ev_ch   = ch_q;
  assign ev_cont = cur_cont;
  assign ev_skip = skip_q;
endmodule

// File: rtl/evt_xfer_unit.sv
module evt_xfer_unit
  import pet_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         trig_i,
  input  logic                   cfg_we_i,
  input  logic [$clog2(NCH)-1:0] cfg_ch_i,
  input  logic [1:0]             cfg_sel_i,
  input  logic [AW-1:0]          cfg_wdata_i,
  output logic [AW-1:0]          cfg_rdata_o,
  output logic                   bus_req_o,
  output logic                   bus_we_o,
  output logic                   bus_size_o,
  output logic [AW-1:0]          bus_addr_o,
  output logic [DW-1:0]          bus_wdata_o,
  input  logic [DW-1:0]          bus_rdata_i,
  output logic                   steal_o,
  output logic                   done_o,
  output logic [NCH-1:0]         irq_o
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0][AW-1:0] src_all, dst_all;
  logic [NCH-1:0][CW+3:0] ctrl_all;
  logic [NCH-1:0]         pend, clr_oh, upd_oh;
  logic [AW-1:0]          upd_src, upd_dst;
  logic [CW-1:0]          upd_cnt;
  logic                   pick_vld;
  logic [CHW-1:0]         pick_ch;

  // named internal events for the checker
  logic [CHW-1:0] ev_ch;
  logic           ev_cont;
  logic           ev_skip;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pet_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we_i && (cfg_ch_i == CHW'(i))),
      .cfg_sel   (cfg_sel_i),
      .cfg_wdata (cfg_wdata_i),
      .upd_en    (upd_oh[i]),
      .upd_src   (upd_src),
      .upd_dst   (upd_dst),
      .upd_cnt   (upd_cnt),
      .trig      (trig_i[i]),
      .clr       (clr_oh[i]),
      .src_q     (src_all[i]),
      .dst_q     (dst_all[i]),
      .ctrl_q    (ctrl_all[i]),
      .pend_q    (pend[i])
    );
  end

  pet_pick #(.NCH(NCH)) u_pick (
    .req (pend),
    .vld (pick_vld),
    .idx (pick_ch)
  );

  pet_engine #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_vld  (pick_vld),
    .pick_ch   (pick_ch),
    .src_all   (src_all),
    .dst_all   (dst_all),
    .ctrl_all  (ctrl_all),
    .bus_rdata (bus_rdata_i),
    .clr_oh    (clr_oh),
    .upd_oh    (upd_oh),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_cnt   (upd_cnt),
    .bus_req   (bus_req_o),
    .bus_we    (bus_we_o),
    .bus_size  (bus_size_o),
    .bus_addr  (bus_addr_o),
    .bus_wdata (bus_wdata_o),
    .done      (done_o),
    .irq       (irq_o),
    .ev_ch     (ev_ch),
    .ev_cont   (ev_cont),
    .ev_skip   (ev_skip)
  );

  assign steal_o = bus_req_o;

  always_comb begin
    case (cfg_sel_i)
      SEL_SRC:  cfg_rdata_o = src_all[cfg_ch_i];
      SEL_DST:  cfg_rdata_o = dst_all[cfg_ch_i];
      SEL_CTRL: cfg_rdata_o = AW'(ctrl_all[cfg_ch_i]);
      default:  cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pet_check.sv
module pet_check #(
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_we,
  input logic                   done,
  input logic [NCH-1:0]         irq,
  input logic [$clog2(NCH)-1:0] ev_ch,
  input logic                   ev_cont,
  input logic                   ev_skip
);

  // R4: a read cycle is always followed by the write cycle of the same slot
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> (bus_req && bus_we));

  // R4: the served channel holds through the slot
  assert_channel_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> $stable(ev_ch));

  // R4: the write is followed by done and a free bus
  assert_done_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> (done && !bus_req));

  // R4: done only ever follows a write cycle
  assert_done_has_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_we));

  // R7: at most one interrupt line at a time
  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R6: a free-running service never interrupts
  assert_free_run_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ev_cont) |-> (irq == '0));

  // R8: an exhausted channel interrupts without touching the bus
  assert_skip_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |-> (!done && (irq != '0) && !$past(bus_req)));

endmodule

bind evt_xfer_unit pet_check #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_req (bus_req_o),
  .bus_we  (bus_we_o),
  .done    (done_o),
  .irq     (irq_o),
  .ev_ch   (ev_ch),
  .ev_cont (ev_cont),
  .ev_skip (ev_skip)
);

// File: tb/sim_evt_xfer_unit.sv
module sim_evt_xfer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_ch_i = '0;
  logic [1:0]  cfg_sel_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        bus_req_o, bus_we_o, bus_size_o;
  logic [15:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        steal_o, done_o;
  logic [7:0]  irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_xfer_unit u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_size_o(bus_size_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .steal_o(steal_o), .done_o(done_o), .irq_o(irq_o)
  );

  // byte-wide memory model, little-endian words
  logic [7:0] mem [0:1023];
  logic [9:0] ma0, ma1;
  assign ma0 = bus_addr_o[9:0];
  assign ma1 = ma0 + 10'd1;
  assign bus_rdata_i = bus_size_o ? {mem[ma1], mem[ma0]} : {8'h00, mem[ma0]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 5);
    end else if (bus_req_o && bus_we_o) begin
      mem[ma0] = bus_wdata_o[7:0];
      if (bus_size_o) mem[ma1] = bus_wdata_o[15:8];
    end
  end

  // scoreboard
  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    logic        size;
    string       tag;
  } item_t;
  item_t sbq[$];
  item_t mon_it;

  int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
  int steal_cnt = 0, done_cnt = 0;
  int irq_cnt [NCH];
  bit finished = 1'b0;

  // bench model of the channel registers
  logic [15:0] m_src [NCH];
  logic [15:0] m_dst [NCH];
  logic [7:0]  m_cnt [NCH];
  bit          m_word [NCH];
  logic [1:0]  m_adv [NCH];
  bit          m_free [NCH];
  int          exp_irq [NCH];
  int          slots = 0;

  initial for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (steal_o) steal_cnt++;
      if (done_o) done_cnt++;
      for (int c = 0; c < NCH; c++) if (irq_o[c]) irq_cnt[c]++;
      if (bus_req_o && bus_we_o) begin
        mon_chk++;
        if (sbq.size() == 0) begin
          mon_err++;
          $display("FAIL R2: unexpected write addr %h data %h, expected none", bus_addr_o, bus_wdata_o);
        end else begin
          mon_it = sbq.pop_front();
          if (bus_addr_o != mon_it.addr || bus_wdata_o != mon_it.data || bus_size_o != mon_it.size) begin
            mon_err++;
            $display("FAIL %s: write addr %h data %h size %0d, expected addr %h data %h size %0d",
                     mon_it.tag, bus_addr_o, bus_wdata_o, bus_size_o,
                     mon_it.addr, mon_it.data, mon_it.size);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int c, input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_ch_i = 3'(c); cfg_sel_i = sel; cfg_wdata_i = v;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(input int c, input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    cfg_ch_i = 3'(c); cfg_sel_i = sel;
    #1 v = cfg_rdata_o;
  endtask

  task automatic prog(input int c, input logic [15:0] s, input logic [15:0] d,
                      input logic [7:0] cnt, input bit word, input logic [1:0] adv,
                      input bit free);
    logic [15:0] ctl, rb;
    ctl = {4'b0000, free, adv, word, cnt};
    cfg_wr(c, 2'd0, s);
    cfg_wr(c, 2'd1, d);
    cfg_wr(c, 2'd2, ctl);
    m_src[c] = s; m_dst[c] = d; m_cnt[c] = cnt;
    m_word[c] = word; m_adv[c] = adv; m_free[c] = free;
    cfg_rd(c, 2'd2, rb);
    chk(rb == ctl, "R1 control readback", rb, ctl);
  endtask

  // predict one service of channel c
  task automatic model_step(input int c, input string tag);
    item_t it;
    logic [9:0] s;
    int inc;
    if (!m_free[c] && m_cnt[c] == 0) begin
      exp_irq[c]++;
    end else begin
      s = m_src[c][9:0];
      it.addr = m_dst[c];
      it.data = m_word[c] ? {mem[s + 10'd1], mem[s]} : {8'h00, mem[s]};
      it.size = m_word[c];
      it.tag  = tag;
      sbq.push_back(it);
      inc = m_word[c] ? 2 : 1;
      if (m_adv[c] == 2'b01) m_src[c] = m_src[c] + 16'(inc);
      if (m_adv[c] == 2'b10) m_dst[c] = m_dst[c] + 16'(inc);
      if (!m_free[c]) begin
        m_cnt[c] = m_cnt[c] - 8'd1;
        if (m_cnt[c] == 0) exp_irq[c]++;
      end
      slots++;
    end
  endtask

  task automatic serve(input logic [7:0] mask, input string tag);
    int n = 0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (mask[c]) begin
        model_step(c, tag);
        n++;
      end
    end
    @(negedge clk);
    trig_i = mask;
    @(negedge clk);
    trig_i = '0;
    repeat (4 * n + 6) @(negedge clk);
  endtask

  task automatic chk_regs(input int c, input string tag);
    logic [15:0] v;
    cfg_rd(c, 2'd0, v);
    chk(v == m_src[c], {tag, " source pointer"}, v, m_src[c]);
    cfg_rd(c, 2'd1, v);
    chk(v == m_dst[c], {tag, " destination pointer"}, v, m_dst[c]);
    cfg_rd(c, 2'd2, v);
    chk(v[7:0] == m_cnt[c], {tag, " count"}, v[7:0], m_cnt[c]);
  endtask

  initial begin
    logic [15:0] v;
    int st0;
    for (int c = 0; c < NCH; c++) exp_irq[c] = 0;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk(!steal_o && !bus_req_o && !done_o && irq_o == 0, "R10 outputs in reset",
        {steal_o, bus_req_o, done_o, irq_o}, 0);
    rst_n = 1'b1;
    cfg_rd(3, 2'd0, v);
    chk(v == 0, "R10 source pointer after reset", v, 0);
    cfg_rd(3, 2'd2, v);
    chk(v == 0, "R10 control after reset", v, 0);
    cfg_rd(3, 2'd3, v);
    chk(v == 0, "R1 unused select reads zero", v, 0);

    // R3 R5 R7: word moves advancing the source, count 3
    prog(2, 16'h0100, 16'h0200, 8'd3, 1'b1, 2'b01, 1'b0);
    serve(8'h04, "R2 word move");
    chk_regs(2, "R3 R5 first word");
    serve(8'h04, "R2 word move");
    chk(irq_cnt[2] == 0, "R7 no interrupt before zero", irq_cnt[2], 0);
    serve(8'h04, "R2 word move");
    chk_regs(2, "R3 R5 third word");
    chk(irq_cnt[2] == 1, "R7 interrupt at zero", irq_cnt[2], 1);

    // R3: byte moves advancing the destination
    prog(5, 16'h0040, 16'h0300, 8'd2, 1'b0, 2'b10, 1'b0);
    serve(8'h20, "R2 byte move");
    serve(8'h20, "R2 byte move");
    chk_regs(5, "R3 byte destination advance");
    chk(irq_cnt[5] == 1, "R7 byte channel interrupt", irq_cnt[5], 1);

    // R3: no advance, on the lowest channel
    prog(0, 16'h0080, 16'h02A0, 8'd5, 1'b1, 2'b00, 1'b0);
    serve(8'h01, "R2 fixed pointers");
    chk_regs(0, "R3 mode 00 holds pointers");
    prog(0, 16'h0090, 16'h02B0, 8'd5, 1'b0, 2'b11, 1'b0);
    serve(8'h01, "R2 fixed pointers");
    chk_regs(0, "R3 mode 11 holds pointers");

    // R6: free-running from a zero count, highest channel
    prog(7, 16'h0060, 16'h0380, 8'd0, 1'b1, 2'b10, 1'b1);
    repeat (3) serve(8'h80, "R6 free-running move");
    chk_regs(7, "R6 count held");
    chk(irq_cnt[7] == 0, "R6 no interrupt", irq_cnt[7], 0);

    // R8: exhausted channel
    prog(3, 16'h00C0, 16'h03C0, 8'd0, 1'b1, 2'b01, 1'b0);
    st0 = steal_cnt;
    serve(8'h08, "R8 must not move");
    chk(steal_cnt == st0, "R8 no bus slot taken", steal_cnt, st0);
    chk(irq_cnt[3] == 1, "R8 interrupt forwarded", irq_cnt[3], 1);
    chk_regs(3, "R8 registers untouched");

    // R9: simultaneous triggers, channel 6 before channel 1
    prog(1, 16'h0010, 16'h0320, 8'd4, 1'b1, 2'b01, 1'b0);
    prog(6, 16'h0020, 16'h0340, 8'd4, 1'b0, 2'b10, 1'b0);
    serve(8'h42, "R9 priority order");
    chk_regs(1, "R9 low channel served");
    chk_regs(6, "R9 high channel served");

    // R4 R7: slot accounting and interrupt totals
    chk(sbq.size() == 0, "R2 all predicted writes seen", sbq.size(), 0);
    chk(steal_cnt == 2 * slots, "R4 two stolen cycles per move", steal_cnt, 2 * slots);
    chk(done_cnt == slots, "R4 one done per move", done_cnt, slots);
    for (int c = 0; c < NCH; c++)
      chk(irq_cnt[c] == exp_irq[c], "R7 interrupt total", irq_cnt[c], exp_irq[c]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk, n_err + mon_err);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", WD_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk + 1, n_err + mon_err + 1);
      $finish;
    end
  end
endmodule